// File: doc/BRIEF.md
# SDRAM Bring-Up Sequencer

This block takes a synchronous DRAM from power-on to its first usable state. After reset it keeps the memory deselected for a programmable settling time. It then waits for software to request the bring-up commands. Software sets a pending flag and follows it with an ordinary host access. The access is held off until the command can legally go out, and it is acknowledged on the same cycle the command is committed.

Three commands take part in the sequence. Precharge-all is requested through `cfg_pall_set`. Periodic auto-refresh starts once `cfg_rfen` is high. Mode-register load is requested through `cfg_mrs_set`. The mode word comes from the host access address, with two fields forced by the block: the burst length is fixed to a single beat, and the CAS latency field is taken from `cfg_cas_lat`. The mode load is not issued until eight refreshes have gone out. Every command loads a recovery counter, and that counter blocks the next command until the recovery time has passed. `init_done` rises once the mode load has recovered.

Top module: `sdram_bringup_seq`

## Requirements
- R1: While `rst` is high and after it, the command pins stay deselected (all four high) until a command is issued. During reset `host_rdy`, `pall_pend`, `mrs_pend` and `init_done` are low.
- R2: Counting the first clock edge with `rst` low as cycle 1, no command appears and `host_rdy` stays low before cycle PWRUP_CYC. A request pending from reset gets `host_rdy` in cycle PWRUP_CYC, and its command is visible in cycle PWRUP_CYC+1.
- R3: After a pulse on `cfg_pall_set`, a host access produces one precharge-all command. Its pin code is cs/ras/cas/we = 0/0/1/0, `sd_addr[10]` is 1 and all other `sd_addr` bits are 0. `pall_pend` reads 0 from the cycle the command is visible.
- R4: After a command, the next command appears no sooner than TRP cycles after a precharge-all, TRFC cycles after a refresh, and TMRD cycles after a mode load.
- R5: While `cfg_rfen` is high, a refresh falls due every REF_INT_CYC cycles. Refreshes that are not delayed appear exactly REF_INT_CYC cycles apart, with pin code 0/0/0/1.
- R6: A mode-load access is stalled (`host_rdy` low) until MIN_REFS refreshes have been issued since reset. When the request has been waiting, the mode load appears exactly TRFC cycles after the last of those refreshes.
- R7: The mode load has pin code 0/0/0/0. `sd_addr` equals `host_addr[ROW_W-1:0]` except that bits [2:0] are 000 and bits [6:4] equal {0,`cfg_cas_lat`}. `sd_ba` equals `host_addr[ROW_W+BA_W-1:ROW_W]`. `mrs_pend` reads 0 from the cycle the command is visible.
- R8: `init_done` rises exactly TMRD cycles after the mode load is visible and stays high until reset.
- R9: If a refresh is due in the same cycle that a triggered command is eligible, the refresh goes first. The triggered command follows TRFC cycles later.
- R10: After power-up, a host access with no pending flag is acknowledged through `host_rdy` and issues no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pall_set | input | 1 | Pulse: arm the precharge-all request |
| cfg_mrs_set | input | 1 | Pulse: arm the mode-load request |
| cfg_rfen | input | 1 | Level: periodic refresh enabled |
| cfg_cas_lat | input | 2 | CAS latency written into the mode word (1 to 3) |
| host_req | input | 1 | Host access strobe, held until acknowledged |
| host_addr | input | ROW_W+BA_W | Host access address |
| host_rdy | output | 1 | Access accepted this cycle |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ROW_W | Memory address bus |
| sd_ba | output | BA_W | Bank select |
| pall_pend | output | 1 | Precharge-all request armed |
| mrs_pend | output | 1 | Mode-load request armed |
| init_done | output | 1 | Mode load completed and recovered |

## Verification
The clearest signs of a wrong internal state are in command timing. A miscounted power-up or recovery counter moves the first command, or the gap between two commands, by a whole cycle. This shows at the pins on the very next command. A refresh counter that runs fast or slow shows in two places: the spacing between refreshes, and how many refreshes come before the stalled mode load. Both are visible within one refresh interval. A wrong arbitration choice shows in which command comes out first when a refresh and a triggered command collide. A pending flag that fails to clear shows as a spurious second command at the next host access.

// File: rtl/sdram_bringup_pkg.sv
package sdram_bringup_pkg;

    // Pin code order: {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_DESEL = 4'b1111,
        CMD_PALL  = 4'b0010,
        CMD_REF   = 4'b0001,
        CMD_MRS   = 4'b0000
    } sd_cmd_e;

    typedef struct packed {
        logic    fire;   // a command is committed this cycle
        logic    ack;    // host access accepted this cycle
        sd_cmd_e cmd;
    } pick_t;

    // Mode word field layout seen by the memory device
    localparam int BL_LSB = 0;
    localparam int BL_W   = 3;
    localparam int CL_LSB = 4;
    localparam int CL_W   = 3;
    localparam int AP_BIT = 10;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sbs_pwrup_timer.sv
module sbs_pwrup_timer #(
    parameter int CYC = 10000
) (
    input  logic clk,
    input  logic rst,
    output logic ok
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt != CW'(CYC))
            cnt <= cnt + 1'b1;
    end

    assign ok = (cnt == CW'(CYC));
endmodule

// File: rtl/sbs_holdoff.sv
module sbs_holdoff #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         busy
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/sbs_refresh_sched.sv
module sbs_refresh_sched #(
    parameter int INT_CYC  = 780,
    parameter int MIN_REFS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic issued,
    output logic due,
    output logic enough
);
    localparam int IW = $clog2(INT_CYC);
    localparam int RW = $clog2(MIN_REFS + 1);

    logic [IW-1:0] ival;
    logic [RW-1:0] refs;
    logic          wrap;

    assign wrap = en && (ival == IW'(INT_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || !en)
            ival <= '0;
        else if (wrap)
            ival <= '0;
        else
            ival <= ival + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !en)
            due <= 1'b0;
        else if (wrap)
            due <= 1'b1;
        else if (issued)
            due <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            refs <= '0;
        else if (issued && refs != RW'(MIN_REFS))
            refs <= refs + 1'b1;
    end

    assign enough = (refs == RW'(MIN_REFS));
endmodule

// File: rtl/sdram_bringup_seq.sv
module sdram_bringup_seq
    import sdram_bringup_pkg::*;
#(
    parameter int ROW_W       = 12,
    parameter int BA_W        = 2,
    parameter int PWRUP_CYC   = 10000,
    parameter int REF_INT_CYC = 780,
    parameter int MIN_REFS    = 8,
    parameter int TRP         = 3,
    parameter int TRFC        = 7,
    parameter int TMRD        = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_pall_set,
    input  logic                  cfg_mrs_set,
    input  logic                  cfg_rfen,
    input  logic [1:0]            cfg_cas_lat,
    input  logic                  host_req,
    input  logic [ROW_W+BA_W-1:0] host_addr,
    output logic                  host_rdy,
    output logic                  sd_cs_n,
    output logic                  sd_ras_n,
    output logic                  sd_cas_n,
    output logic                  sd_we_n,
    output logic [ROW_W-1:0]      sd_addr,
    output logic [BA_W-1:0]       sd_ba,
    output logic                  pall_pend,
    output logic                  mrs_pend,
    output logic                  init_done
);
    localparam int HOLD_MAX = max3(TRP, TRFC, TMRD);
    localparam int HW       = $clog2(HOLD_MAX + 1);
    localparam logic [ROW_W-1:0] FIELD_MASK =
        ROW_W'(((1 << BL_W) - 1) << BL_LSB) | ROW_W'(((1 << CL_W) - 1) << CL_LSB);

    logic           pwr_ok, busy, ref_due, refs_met, ref_issue;
    logic           mrs_wait;
    pick_t          pick;
    sd_cmd_e        cmd_q;
    logic [HW-1:0]  hold_val;
    logic [ROW_W-1:0] mode_word;

    sbs_pwrup_timer #(.CYC(PWRUP_CYC)) u_pwr (
        .clk(clk), .rst(rst), .ok(pwr_ok)
    );

    sbs_holdoff #(.W(HW)) u_hold (
        .clk(clk), .rst(rst), .load(pick.fire), .load_val(hold_val), .busy(busy)
    );

    sbs_refresh_sched #(.INT_CYC(REF_INT_CYC), .MIN_REFS(MIN_REFS)) u_ref (
        .clk(clk), .rst(rst), .en(cfg_rfen), .issued(ref_issue),
        .due(ref_due), .enough(refs_met)
    );

    // Arbitration: refresh first, then precharge-all, then mode load, then plain ack
    always_comb begin
        pick = '{fire: 1'b0, ack: 1'b0, cmd: CMD_DESEL};
        if (pwr_ok && !busy) begin
            if (ref_due) begin
                pick.fire = 1'b1;
                pick.cmd  = CMD_REF;
            end else if (host_req) begin
                if (pall_pend) begin
                    pick = '{fire: 1'b1, ack: 1'b1, cmd: CMD_PALL};
                end else if (mrs_pend) begin
                    if (refs_met)
                        pick = '{fire: 1'b1, ack: 1'b1, cmd: CMD_MRS};
                end else begin
                    pick.ack = 1'b1;
                end
            end
        end
    end

    assign ref_issue = pick.fire && (pick.cmd == CMD_REF);
    assign host_rdy  = pick.ack;

    always_comb begin
        case (pick.cmd)
            CMD_PALL: hold_val = HW'(TRP - 1);
            CMD_REF:  hold_val = HW'(TRFC - 1);
            CMD_MRS:  hold_val = HW'(TMRD - 1);
            default:  hold_val = '0;
        endcase
    end

    // Burst length forced to one beat, latency field from configuration
    always_comb
        mode_word = (host_addr[ROW_W-1:0] & ~FIELD_MASK)
                  | (ROW_W'({1'b0, cfg_cas_lat}) << CL_LSB);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= CMD_DESEL;
            sd_addr <= '0;
            sd_ba   <= '0;
        end else begin
            cmd_q   <= pick.fire ? pick.cmd : CMD_DESEL;
            sd_addr <= '0;
            sd_ba   <= '0;
            if (pick.fire && pick.cmd == CMD_PALL)
                sd_addr <= ROW_W'(1) << AP_BIT;
            if (pick.fire && pick.cmd == CMD_MRS) begin
                sd_addr <= mode_word;
                sd_ba   <= host_addr[ROW_W +: BA_W];
            end
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pall_pend <= 1'b0;
            mrs_pend  <= 1'b0;
            mrs_wait  <= 1'b0;
            init_done <= 1'b0;
        end else begin
            if (cfg_pall_set)
                pall_pend <= 1'b1;
            else if (pick.fire && pick.cmd == CMD_PALL)
                pall_pend <= 1'b0;

            if (cfg_mrs_set)
                mrs_pend <= 1'b1;
            else if (pick.fire && pick.cmd == CMD_MRS)
                mrs_pend <= 1'b0;

            if (pick.fire && pick.cmd == CMD_MRS)
                mrs_wait <= 1'b1;
            else if (mrs_wait && !busy) begin
                mrs_wait  <= 1'b0;
                init_done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sdram_bringup_chk.sv
module sdram_bringup_chk
    import sdram_bringup_pkg::*;
#(
    parameter int ROW_W     = 12,
    parameter int PWRUP_CYC = 10000,
    parameter int MIN_REFS  = 8,
    parameter int TRP       = 3,
    parameter int TRFC      = 7,
    parameter int TMRD      = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             host_rdy,
    input logic             sd_cs_n,
    input logic             sd_ras_n,
    input logic             sd_cas_n,
    input logic             sd_we_n,
    input logic [ROW_W-1:0] sd_addr,
    input logic             pall_pend,
    input logic             mrs_pend,
    input logic             init_done
);
    localparam int HOLD_MAX = max3(TRP, TRFC, TMRD);
    localparam int GW       = $clog2(HOLD_MAX + 2);
    localparam int PW       = $clog2(PWRUP_CYC + 2);
    localparam int RW       = $clog2(MIN_REFS + 1);

    logic [3:0]    cmd;
    logic [PW-1:0] pw;
    logic [GW-1:0] since, need;
    logic [RW-1:0] refs;

    assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    always_ff @(posedge clk) begin
        if (rst) begin
            pw    <= '0;
            since <= GW'(HOLD_MAX + 1);
            need  <= '0;
            refs  <= '0;
        end else begin
            if (pw != PW'(PWRUP_CYC + 1))
                pw <= pw + 1'b1;
            if (!sd_cs_n) begin
                since <= GW'(1);
                case (cmd)
                    CMD_PALL: need <= GW'(TRP);
                    CMD_REF:  need <= GW'(TRFC);
                    CMD_MRS:  need <= GW'(TMRD);
                    default:  need <= '0;
                endcase
            end else if (since != GW'(HOLD_MAX + 1)) begin
                since <= since + 1'b1;
            end
            if (cmd == CMD_REF && refs != RW'(MIN_REFS))
                refs <= refs + 1'b1;
        end
    end

    p_idle_in_reset_r1: assert property (@(posedge clk)
        rst |=> (sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n && !init_done));

    p_no_rdy_in_reset_r1: assert property (@(posedge clk)
        rst |-> !host_rdy);

    p_no_cmd_early_r2: assert property (@(posedge clk) disable iff (rst)
        !sd_cs_n |-> (pw > PW'(PWRUP_CYC)));

    p_no_rdy_early_r2: assert property (@(posedge clk) disable iff (rst)
        host_rdy |-> (pw >= PW'(PWRUP_CYC)));

    p_pall_form_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_PALL) |-> (sd_addr[AP_BIT] && !pall_pend));

    p_cmd_spacing_r4: assert property (@(posedge clk) disable iff (rst)
        !sd_cs_n |-> (since >= need));

    p_mrs_after_refs_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_MRS) |-> (refs == RW'(MIN_REFS)));

    p_mrs_one_beat_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_MRS) |-> (sd_addr[BL_LSB +: BL_W] == '0 && !mrs_pend));

    p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);
endmodule

bind sdram_bringup_seq sdram_bringup_chk #(
    .ROW_W(ROW_W), .PWRUP_CYC(PWRUP_CYC), .MIN_REFS(MIN_REFS),
    .TRP(TRP), .TRFC(TRFC), .TMRD(TMRD)
) u_chk (
    .clk(clk), .rst(rst), .host_rdy(host_rdy),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_addr(sd_addr), .pall_pend(pall_pend), .mrs_pend(mrs_pend), .init_done(init_done)
);

// File: tb/sdram_bringup_seq_tb.sv
module sdram_bringup_seq_tb_top;
    localparam int ROW_W = 12, BA_W = 2;
    localparam int PWRUP = 200, RINT = 50, MINR = 8;
    localparam int TRP = 3, TRFC = 7, TMRD = 2;

    logic clk = 1'b0, rst = 1'b1;
    logic cfg_pall_set = 0, cfg_mrs_set = 0, cfg_rfen = 0;
    logic [1:0] cfg_cas_lat = 2'd1;
    logic host_req = 0;
    logic [ROW_W+BA_W-1:0] host_addr = '0;
    logic host_rdy, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [ROW_W-1:0] sd_addr;
    logic [BA_W-1:0] sd_ba;
    logic pall_pend, mrs_pend, init_done;

    int checks = 0, fails = 0;
    int cyc = 0;
    int n_cmds = 0, n_ref = 0, last_cmd_cyc = 0, last_ref_cyc = 0, need_gap = 0;
    logic [3:0] last_cmd = 4'hF;

    always #5 clk = ~clk;

    sdram_bringup_seq #(
        .ROW_W(ROW_W), .BA_W(BA_W), .PWRUP_CYC(PWRUP), .REF_INT_CYC(RINT),
        .MIN_REFS(MINR), .TRP(TRP), .TRFC(TRFC), .TMRD(TMRD)
    ) dut_i (
        .clk(clk), .rst(rst), .cfg_pall_set(cfg_pall_set), .cfg_mrs_set(cfg_mrs_set),
        .cfg_rfen(cfg_rfen), .cfg_cas_lat(cfg_cas_lat), .host_req(host_req),
        .host_addr(host_addr), .host_rdy(host_rdy), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_addr(sd_addr), .sd_ba(sd_ba), .pall_pend(pall_pend),
        .mrs_pend(mrs_pend), .init_done(init_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    // Command monitor, sampling 2 ns after the edge
    always begin
        @(posedge clk);
        #2;
        if (rst) begin
            n_cmds = 0; n_ref = 0; need_gap = 0; last_cmd = 4'hF;
        end else if (!sd_cs_n) begin
            if (n_cmds > 0)
                chk(cyc - last_cmd_cyc >= need_gap, "R4 gap", cyc - last_cmd_cyc, need_gap);
            last_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            case (last_cmd)
                4'b0010: need_gap = TRP;
                4'b0001: need_gap = TRFC;
                4'b0000: need_gap = TMRD;
                default: need_gap = 0;
            endcase
            if (last_cmd == 4'b0001) begin
                if (n_ref > 0)
                    chk(cyc - last_ref_cyc == RINT, "R5 interval", cyc - last_ref_cyc, RINT);
                n_ref++;
                last_ref_cyc = cyc;
            end
            n_cmds++;
            last_cmd_cyc = cyc;
        end
    end

    task automatic wait_rdy();
        @(negedge clk);
        while (!host_rdy) @(negedge clk);
    endtask

    task automatic do_reset(input bit rfen);
        rst = 1'b1; host_req = 0; cfg_rfen = 0;
        repeat (4) @(negedge clk);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'hF, "R1 pins in reset",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 15);
        chk(!host_rdy && !pall_pend && !mrs_pend && !init_done, "R1 flags in reset",
            {host_rdy, pall_pend, mrs_pend, init_done}, 0);
        cfg_rfen = rfen;
        rst = 1'b0;
    endtask

    // R1 R2 R3 R10
    task automatic test_pall();
        int first;
        do_reset(1'b0);
        cfg_pall_set = 1; host_req = 1;
        @(negedge clk);
        cfg_pall_set = 0;
        chk(pall_pend, "R3 pend armed", pall_pend, 1);
        while (!host_rdy) @(negedge clk);
        first = cyc;
        chk(first == PWRUP, "R2 first rdy cycle", first, PWRUP);
        chk(n_cmds == 0, "R2 no early command", n_cmds, 0);
        @(negedge clk);
        host_req = 0;
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0010, "R3 pall code",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 2);
        chk(cyc == PWRUP + 1, "R2 first command cycle", cyc, PWRUP + 1);
        chk(sd_addr == 12'h400, "R3 pall address", sd_addr, 12'h400);
        chk(!pall_pend, "R3 pend self-clear", pall_pend, 0);
        // R10: access without a pending flag
        host_req = 1;
        wait_rdy();
        @(negedge clk);
        host_req = 0;
        first = n_cmds;
        repeat (6) @(negedge clk);
        chk(n_cmds == first, "R10 plain access issues nothing", n_cmds, first);
        chk(sd_cs_n, "R10 pins idle", sd_cs_n, 1);
    endtask

    // R5 R6 R7 R8
    task automatic test_mrs();
        int base, mcyc;
        logic [ROW_W-1:0] em;
        cfg_rfen = 1; cfg_mrs_set = 1; cfg_cas_lat = 2'd2;
        host_addr = 14'h2A77; host_req = 1;
        base = n_ref;
        @(negedge clk);
        cfg_mrs_set = 0;
        chk(mrs_pend, "R7 pend armed", mrs_pend, 1);
        while (!host_rdy) @(negedge clk);
        chk(n_ref - base == MINR, "R6 refreshes before mode load", n_ref - base, MINR);
        @(negedge clk);
        host_req = 0;
        mcyc = cyc;
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0000, "R7 mrs code",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 0);
        chk(mcyc == last_ref_cyc + TRFC, "R6 mode load timing", mcyc, last_ref_cyc + TRFC);
        em = host_addr[ROW_W-1:0];
        em[2:0] = 3'b000;
        em[6:4] = {1'b0, cfg_cas_lat};
        chk(sd_addr == em, "R7 mode word", sd_addr, em);
        chk(sd_ba == 2'b10, "R7 bank", sd_ba, 2);
        chk(!mrs_pend, "R7 pend self-clear", mrs_pend, 0);
        @(negedge clk);
        chk(!init_done, "R8 done not early", init_done, 0);
        @(negedge clk);
        chk(init_done && cyc == mcyc + TMRD, "R8 done timing", cyc, mcyc + TMRD);
        repeat (2 * RINT) @(negedge clk);
        chk(init_done, "R8 done sticky", init_done, 1);
        chk(n_ref - base >= MINR + 2, "R5 refresh continues", n_ref - base, MINR + 2);
    endtask

    // R9 R1 R8
    task automatic test_prio();
        int rcyc;
        do_reset(1'b1);
        cfg_pall_set = 1; host_req = 1;
        @(negedge clk);
        cfg_pall_set = 0;
        chk(!init_done, "R8 cleared by reset", init_done, 0);
        while (n_cmds == 0) @(negedge clk);
        rcyc = cyc;
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0001, "R9 refresh first",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 1);
        chk(rcyc == PWRUP + 1, "R9 refresh cycle", rcyc, PWRUP + 1);
        while (!host_rdy) @(negedge clk);
        @(negedge clk);
        host_req = 0;
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0010, "R9 pall second",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 2);
        chk(cyc == rcyc + TRFC, "R9 pall after tRFC", cyc, rcyc + TRFC);
        repeat (RINT + 5) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        test_pall();
        test_mrs();
        test_prio();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule